// File: doc/BRIEF.md
# Byte-wide UART Register Front-End

This block gives a host a register-compatible view of a classic PC serial port without the serial line behind it. The host reads and writes eight byte registers through a simple strobed bus with a 3-bit offset. Characters the host sends come out on a one-cycle strobed byte output. Bytes from outside enter through a valid/ready stream and wait in a receive queue until the host reads them. A single-cycle interrupt pulse tells the host that a transmit or receive event has occurred.

The block holds the 16-bit divisor latch, the interrupt enable and identification logic, the line control, modem control and scratch registers, and a parameterised receive queue of 64 bytes by default. The same queue serves internal loopback: while loopback is on, bytes the host writes go back into the queue and the external stream is refused. Several details differ from the classic part. Reading the identification register clears it. Loopback stores bytes in the bounded queue rather than a shift register. Reset values are fixed. Baud generation, line framing, modem pins and FIFO control are not modelled.

Top module: `uart_regfile_front`

## Requirements
- R1: After reset, the offsets read as follows: 1 (interrupt enable) 0x00, 2 (identification) 0xC1, 3 (line control) 0x03, 4 (modem control) 0x08, 5 (line status) 0x60, 6 (modem status) 0xB0 and 7 (scratch) 0x00.
- R2: While line-control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. The divisor resets to 12. Such accesses leave the queue, the transmit output and the interrupt enable untouched.
- R3: A write to offset 1 (with line-control bit 7 clear) stores only the low four bits of the written value, and reads return them with the upper nibble 0.
- R4: A read of offset 2 returns the identification value ORed with 0xC0. Afterwards the register holds 0x01 unless a new event sets a bit in the same cycle.
- R5: In the identification value, bit 1 means a transmit event is pending and bit 2 means a receive event is pending. Bit 0 is 1 exactly when neither is pending.
- R6: With loopback off, a data write puts the byte on tx_byte with tx_valid high for exactly the next cycle. If interrupt-enable bit 1 is set, it also sets identification bit 1 and pulses irq_pulse.
- R7: An external byte is accepted in a cycle with rx_valid and rx_ready both high. Acceptance sets line-status bit 0. If interrupt-enable bit 0 is set, it also sets identification bit 2 and pulses irq_pulse.
- R8: A data read returns the oldest queued byte and removes it, or returns 0x00 when the queue is empty. It clears identification bit 2. Line-status bit 0 reads 1 exactly while the queue is non-empty.
- R9: While modem-control bit 4 is set, a data write is appended to the queue if it holds fewer than QUEUE_DEPTH bytes and is dropped otherwise. Nothing appears on the transmit output.
- R10: rx_ready is low while loopback is on or the queue is full. A byte offered then is not stored.
- R11: Writes to line status (offset 5) and modem status (offset 6) have no effect. Scratch (offset 7) reads back the last value written.
- R12: A data read and a queue append in the same cycle both take effect. The occupancy is unchanged, line-status bit 0 stays 1, and identification bit 2 ends set if receive interrupts are enabled.
- R13: irq_pulse is high for one cycle after each cycle that contains a triggering event, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmitted byte |
| rx_valid | input | 1 | External byte offered |
| rx_ready | output | 1 | Queue can take an external byte |
| rx_byte | input | 8 | External byte |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
A host data read and an external byte append can fall in the same cycle, and each touches the occupancy, line-status bit 0 and identification bit 2. The bench first fills the queue to capacity, drains it to one byte, and then asserts bus_rd at offset 0 in the same cycle as rx_valid. It expects the read to return the old head and line status to stay 0x61. It then expects the appended byte on the next read, identification 0xC4, and an interrupt pulse for the append.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
   typedef enum logic [2:0] {
      OFS_DATA    = 3'd0,
      OFS_IEN     = 3'd1,
      OFS_IID     = 3'd2,
      OFS_LCTL    = 3'd3,
      OFS_MCTL    = 3'd4,
      OFS_LSTAT   = 3'd5,
      OFS_MSTAT   = 3'd6,
      OFS_SCRATCH = 3'd7
   } ofs_e;

   localparam logic [7:0] LCTL_RST    = 8'h03;
   localparam logic [7:0] MCTL_RST    = 8'h08;
   localparam logic [7:0] MSTAT_VAL   = 8'hB0;
   localparam logic [7:0] LSTAT_BASE  = 8'h60;
   localparam logic [7:0] IID_FIFO_OR = 8'hC0;
   localparam int         DLAB_POS    = 7;
   localparam int         LOOP_POS    = 4;
endpackage

// File: rtl/uart_fe_rxq.sv
module uart_fe_rxq #(
   parameter int W     = 8,
   parameter int DEPTH = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 push_data,
   input  logic                         pop,
   output logic [W-1:0]                 head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full,
   output logic                         empty
);
   localparam int CW   = $clog2(DEPTH + 1);
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = (DEPTH == (1 << PW));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_fe_rxq: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("uart_fe_rxq: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rd_ptr];

   generate
      if (POW2) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uart_fe_intid.sv
module uart_fe_intid (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_all,
   input  logic       clr_recv,
   input  logic       set_thr,
   input  logic       set_recv,
   output logic [7:0] iir_raw,
   output logic       irq_pulse
);
   logic pend_thr, pend_recv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_thr  <= 1'b0;
         pend_recv <= 1'b0;
         irq_pulse <= 1'b0;
      end else begin
         pend_thr  <= set_thr  | (pend_thr  & ~clr_all);
         pend_recv <= set_recv | (pend_recv & ~clr_all & ~clr_recv);
         irq_pulse <= set_thr | set_recv;
      end
   end

   assign iir_raw = {5'b0, pend_recv, pend_thr, ~(pend_recv | pend_thr)};
endmodule

// File: rtl/uart_regfile_front.sv
module uart_regfile_front #(
   parameter int          QUEUE_DEPTH = 64,
   parameter logic [15:0] DIV_RESET   = 16'd12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] bus_addr,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       tx_valid,
   output logic [7:0] tx_byte,
   input  logic       rx_valid,
   output logic       rx_ready,
   input  logic [7:0] rx_byte,
   output logic       irq_pulse
);
   import uart_fe_pkg::*;

   localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

   generate
      if (QUEUE_DEPTH < 2 || QUEUE_DEPTH > 4096) begin : g_bad_depth
         $error("uart_regfile_front: QUEUE_DEPTH out of range");
      end
   endgenerate

   logic [3:0]       ien;
   logic [7:0]       lctl, mctl, scratch;
   logic [15:0]      divisor;
   logic             dlab, loop_en;
   logic             wr_data, rd_data;
   logic             q_push, q_pop, q_full, q_empty, ext_acc;
   logic [7:0]       q_pdata, q_head;
   logic [CNT_W-1:0] q_count;
   logic             set_thr, set_recv, clr_recv, clr_all;
   logic [7:0]       iir_raw, lstat, rd_val;

   assign dlab    = lctl[DLAB_POS];
   assign loop_en = mctl[LOOP_POS];
   assign wr_data = bus_wr && (bus_addr == OFS_DATA) && !dlab;
   assign rd_data = bus_rd && (bus_addr == OFS_DATA) && !dlab;

   // receive path: one append source per cycle, loopback excludes external input
   assign rx_ready = !loop_en && !q_full;
   assign ext_acc  = rx_valid && rx_ready;
   assign q_push   = (wr_data && loop_en && !q_full) || ext_acc;
   assign q_pdata  = loop_en ? bus_wdata : rx_byte;
   assign q_pop    = rd_data && !q_empty;

   uart_fe_rxq #(.W(8), .DEPTH(QUEUE_DEPTH)) i_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (q_pdata),
      .pop       (q_pop),
      .head      (q_head),
      .count     (q_count),
      .full      (q_full),
      .empty     (q_empty)
   );

   // interrupt events
   assign set_thr  = wr_data && !loop_en && ien[1];
   assign set_recv = q_push && ien[0];
   assign clr_recv = rd_data;
   assign clr_all  = bus_rd && (bus_addr == OFS_IID);

   uart_fe_intid i_intid (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_all   (clr_all),
      .clr_recv  (clr_recv),
      .set_thr   (set_thr),
      .set_recv  (set_recv),
      .iir_raw   (iir_raw),
      .irq_pulse (irq_pulse)
   );

   assign lstat = LSTAT_BASE | {7'b0, !q_empty};

   always_comb begin
      rd_val = 8'h00;
      case (bus_addr)
         OFS_DATA:    rd_val = dlab ? divisor[7:0] : (q_empty ? 8'h00 : q_head);
         OFS_IEN:     rd_val = dlab ? divisor[15:8] : {4'b0, ien};
         OFS_IID:     rd_val = iir_raw | IID_FIFO_OR;
         OFS_LCTL:    rd_val = lctl;
         OFS_MCTL:    rd_val = mctl;
         OFS_LSTAT:   rd_val = lstat;
         OFS_MSTAT:   rd_val = MSTAT_VAL;
         OFS_SCRATCH: rd_val = scratch;
         default:     rd_val = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien       <= '0;
         lctl      <= LCTL_RST;
         mctl      <= MCTL_RST;
         scratch   <= '0;
         divisor   <= DIV_RESET;
         bus_rdata <= '0;
         tx_valid  <= 1'b0;
         tx_byte   <= '0;
      end else begin
         tx_valid <= wr_data && !loop_en;
         if (wr_data && !loop_en) tx_byte <= bus_wdata;
         if (bus_rd) bus_rdata <= rd_val;
         if (bus_wr) begin
            case (bus_addr)
               OFS_DATA:    if (dlab) divisor[7:0] <= bus_wdata;
               OFS_IEN:     if (dlab) divisor[15:8] <= bus_wdata;
                            else      ien <= bus_wdata[3:0];
               OFS_LCTL:    lctl    <= bus_wdata;
               OFS_MCTL:    mctl    <= bus_wdata;
               OFS_SCRATCH: scratch <= bus_wdata;
               default:     ;
            endcase
         end
      end
   end
endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk #(
   parameter int DEPTH = 64
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [2:0]                   bus_addr,
   input logic                         bus_wr,
   input logic                         bus_rd,
   input logic [7:0]                   bus_wdata,
   input logic                         tx_valid,
   input logic [7:0]                   tx_byte,
   input logic                         rx_valid,
   input logic                         rx_ready,
   input logic                         irq_pulse,
   input logic                         dlab,
   input logic                         loop_en,
   input logic [$clog2(DEPTH+1)-1:0]   q_count,
   input logic                         q_push,
   input logic                         q_pop,
   input logic [7:0]                   iir_raw
);
   // R6
   tx_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd0 && !dlab && !loop_en)
      |=> (tx_valid && tx_byte == $past(bus_wdata)));

   // R9
   loop_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd0 && loop_en) |=> !tx_valid);

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= DEPTH);

   // R7
   rx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready && !q_pop) |=> (q_count == $past(q_count) + 1'b1));

   // R12
   push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && q_pop) |=> (q_count == $past(q_count)));

   // R4
   iid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 3'd2 && !bus_wr && !(rx_valid && rx_ready))
      |=> (iir_raw == 8'h01));

   // R13
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(bus_wr || (rx_valid && rx_ready)));
endmodule

bind uart_regfile_front uart_fe_chk #(.DEPTH(QUEUE_DEPTH)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .tx_valid  (tx_valid),
   .tx_byte   (tx_byte),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .irq_pulse (irq_pulse),
   .dlab      (dlab),
   .loop_en   (loop_en),
   .q_count   (q_count),
   .q_push    (q_push),
   .q_pop     (q_pop),
   .iir_raw   (iir_raw)
);

// File: tb/test_uart_regfile_front.sv
`timescale 1ns/1ps
module test_uart_regfile_front;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       tx_valid;
   logic [7:0] tx_byte;
   logic       rx_valid = 1'b0;
   logic       rx_ready;
   logic [7:0] rx_byte = '0;
   logic       irq_pulse;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   logic irq_seen;
   logic [7:0] exp_tx [$];

   always #2 clk = ~clk;

   uart_regfile_front i_uart_regfile_front (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .rx_byte(rx_byte), .irq_pulse(irq_pulse)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor for the transmit output (R6, R9, R2)
   always @(negedge clk) begin
      if (rst_n && tx_valid) begin
         checks++;
         if (exp_tx.size() == 0) begin
            errors++;
            $display("FAIL R6 actual=%h expected=none (unexpected transmit)", tx_byte);
         end else begin
            logic [7:0] e;
            e = exp_tx.pop_front();
            if (tx_byte !== e) begin
               errors++;
               $display("FAIL R6 actual=%h expected=%h", tx_byte, e);
            end
         end
      end
   end

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      irq_seen = irq_pulse;
   endtask

   task automatic tx_write(input logic [7:0] d);
      exp_tx.push_back(d);
      bus_write(3'd0, d);
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
      irq_seen = irq_pulse;
   endtask

   task automatic rx_send(input logic [7:0] b, input logic exp_ready, input string req);
      @(negedge clk);
      rx_byte = b; rx_valid = 1'b1;
      chk(req, 16'(rx_ready), 16'(exp_ready));
      @(negedge clk);
      rx_valid = 1'b0;
      irq_seen = irq_pulse;
   endtask

   task automatic read_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
      logic [7:0] v;
      bus_read(a, v);
      chk(req, 16'(v), 16'(exp));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      chk("R1 irq", 16'(irq_pulse), 16'd0);
      chk("R1 tx", 16'(tx_valid), 16'd0);
      read_chk(3'd1, 8'h00, "R1 ien");
      read_chk(3'd2, 8'hC1, "R1 iid");
      read_chk(3'd3, 8'h03, "R1 lctl");
      read_chk(3'd4, 8'h08, "R1 mctl");
      read_chk(3'd5, 8'h60, "R1 lstat");
      read_chk(3'd6, 8'hB0, "R1 mstat");
      read_chk(3'd7, 8'h00, "R1 scratch");

      // R2 divisor latch
      bus_write(3'd3, 8'h80);
      read_chk(3'd0, 8'h0C, "R2 div low reset");
      read_chk(3'd1, 8'h00, "R2 div high reset");
      bus_write(3'd0, 8'h12);
      bus_write(3'd1, 8'h34);
      read_chk(3'd0, 8'h12, "R2 div low");
      read_chk(3'd1, 8'h34, "R2 div high");
      read_chk(3'd3, 8'h80, "R2 lctl");
      read_chk(3'd5, 8'h60, "R2 lstat untouched");
      bus_write(3'd3, 8'h03);
      read_chk(3'd1, 8'h00, "R2 ien untouched");

      // R3 interrupt enable low nibble
      bus_write(3'd1, 8'hFF);
      read_chk(3'd1, 8'h0F, "R3 ien");

      // R11 scratch, read-only status
      bus_write(3'd7, 8'h5A);
      read_chk(3'd7, 8'h5A, "R11 scratch");
      bus_write(3'd5, 8'hFF);
      bus_write(3'd6, 8'h00);
      read_chk(3'd5, 8'h60, "R11 lstat");
      read_chk(3'd6, 8'hB0, "R11 mstat");

      // R6 transmit with interrupt, R4/R5 identification
      bus_write(3'd1, 8'h02);
      tx_write(8'h61);
      chk("R6 irq", 16'(irq_seen), 16'd1);
      @(negedge clk);
      chk("R13 single", 16'(irq_pulse), 16'd0);
      read_chk(3'd2, 8'hC2, "R5 thr pending");
      read_chk(3'd2, 8'hC1, "R4 self clear");
      bus_write(3'd1, 8'h00);
      tx_write(8'h62);
      chk("R6 no irq", 16'(irq_seen), 16'd0);
      read_chk(3'd2, 8'hC1, "R6 iid idle");

      // R7 / R8 external receive
      bus_write(3'd1, 8'h01);
      rx_send(8'h41, 1'b1, "R7 ready");
      chk("R7 irq", 16'(irq_seen), 16'd1);
      rx_send(8'h42, 1'b1, "R7 ready");
      rx_send(8'h43, 1'b1, "R7 ready");
      read_chk(3'd5, 8'h61, "R7 lstat");
      read_chk(3'd2, 8'hC4, "R5 recv pending");
      read_chk(3'd0, 8'h41, "R8 order");
      read_chk(3'd0, 8'h42, "R8 order");
      read_chk(3'd5, 8'h61, "R8 lstat nonempty");
      read_chk(3'd0, 8'h43, "R8 order");
      read_chk(3'd5, 8'h60, "R8 lstat empty");
      read_chk(3'd0, 8'h00, "R8 empty read");

      // R9 / R10 loopback
      bus_write(3'd4, 8'h10);
      read_chk(3'd4, 8'h10, "R9 mctl");
      rx_send(8'h99, 1'b0, "R10 loop ready");
      read_chk(3'd5, 8'h60, "R10 ignored");
      for (int i = 0; i < 64; i++) bus_write(3'd0, 8'(i));
      bus_write(3'd0, 8'hEE);
      for (int i = 0; i < 64; i++) read_chk(3'd0, 8'(i), "R9 loop data");
      read_chk(3'd0, 8'h00, "R9 overflow dropped");
      bus_write(3'd4, 8'h08);
      read_chk(3'd2, 8'hC1, "R8 recv cleared");

      // R10 full queue, then R12 simultaneous read and append
      for (int i = 0; i < 64; i++) rx_send(8'(8'h80 + i), 1'b1, "R10 fill");
      rx_send(8'hAA, 1'b0, "R10 full ready");
      chk("R10 no irq", 16'(irq_seen), 16'd0);
      for (int i = 0; i < 63; i++) read_chk(3'd0, 8'(8'h80 + i), "R10 drain");
      read_chk(3'd2, 8'hC1, "R12 pre iid");
      @(negedge clk);
      bus_addr = 3'd0; bus_rd = 1'b1; rx_byte = 8'h5C; rx_valid = 1'b1;
      chk("R12 ready", 16'(rx_ready), 16'd1);
      @(negedge clk);
      bus_rd = 1'b0; rx_valid = 1'b0;
      chk("R12 rdata", 16'(bus_rdata), 16'h00BF);
      chk("R12 irq", 16'(irq_pulse), 16'd1);
      read_chk(3'd5, 8'h61, "R12 lstat");
      read_chk(3'd2, 8'hC4, "R12 iid");
      read_chk(3'd0, 8'h5C, "R12 appended");
      read_chk(3'd5, 8'h60, "R12 empty");

      repeat (3) @(negedge clk);
      chk("R6 tx drained", 16'(exp_tx.size()), 16'd0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule